// File: doc/BRIEF.md
# Counter Enable Clear Register

This block is the write-one-to-clear face of a performance-monitor enable register. It stores one enable flag for a cycle counter and up to 31 enable flags for event counters. A register write whose data carries a 1 in a bit position switches the matching counter off, and a 0 leaves it alone. A read returns the current on/off state. The stored flags also drive an output vector that the counters use as their count gates. A companion set register, outside this block, turns counters on through a separate set strobe.

The number of event flags that software can see and change, called the limit, is chosen every cycle from the privilege context. A hypervisor partition value applies when the hypervisor level is implemented and enabled and the code is running at application or kernel level. In every other case the implemented-counter count applies.

Flags at or above the limit read as zero and are not cleared by writes. They are not erased either: each keeps its stored value and shows again once the limit rises.

Top module: `pmu_enclr_reg`

## Requirements
- R1: While `rst_n` is low, and immediately after it is released, every stored enable is 0, so `rd_data` and `cnt_en` both read zero.
- R2: A write with a 1 in an accessible bit of `wr_data[31:0]` clears that enable on the next clock edge. A 0 bit changes nothing. `wr_data[63:32]` has no effect. With no write and no set, the enables hold their value.
- R3: When `set_en` is high, each bit `i` of `set_data` turns the matching enable on at the next edge, provided `i` is below `NUM_EVT` or `i` is 31.
- R4: If a set and a clear hit the same bit in the same cycle, that bit is 0 afterwards. Other bits in the set still turn on.
- R5: `rd_data[31]` is the cycle-counter enable. `rd_data[i]` for `i` from 0 to 30 equals enable `i` when `i` is below the current limit, and 0 otherwise. `rd_data[63:32]` is always 0.
- R6: The limit is `part_n` when `hyp_impl` and `hyp_on` are both 1 and `priv_lvl` is 0 (application) or 1 (kernel). For any other combination the limit is `impl_n`. Levels 2 and 3 are the hypervisor and monitor levels.
- R7: A write never clears an event enable at or above the current limit. That enable keeps its stored value, stays visible on `cnt_en`, and appears again on `rd_data` when the limit rises above it.
- R8: A limit value larger than `NUM_EVT` acts as `NUM_EVT`. Bits `NUM_EVT` through 30 are never set and always read as 0.
- R9: `cnt_en` gives the stored enables, with no limit mask applied. Bit 31 is the cycle counter and bit `i` is event counter `i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe for the clear view |
| wr_data | input | 64 | Write data. A 1 clears the matching enable. |
| set_en | input | 1 | Set strobe from the companion set register |
| set_data | input | 32 | Set mask that goes with `set_en` |
| priv_lvl | input | 2 | Current privilege level: 0 application, 1 kernel, 2 hypervisor, 3 monitor |
| hyp_impl | input | 1 | The hypervisor level is implemented |
| hyp_on | input | 1 | The hypervisor level is enabled in the current security state |
| part_n | input | 5 | Hypervisor counter-partition limit |
| impl_n | input | 5 | Implemented event-counter count |
| rd_data | output | 64 | Read image of the enables, with the limit mask applied |
| cnt_en | output | 32 | Stored enables, used as the counter gates |

## Verification
The assertions check every cycle that:
- a cleared bit is 0 after the edge, even when a set hits the same bit;
- a set that is not cancelled lands;
- an idle cycle leaves the enables unchanged;
- no enable outside the access mask ever falls;
- the read image never shows a disabled counter;
- the chosen limit never exceeds `NUM_EVT` or the input it was taken from.

Only the bench scenarios show the rest:
- the exact read image for each limit value;
- the choice of limit across all privilege and hypervisor combinations;
- that hidden enables reappear when the limit is raised;
- that writes to the upper word change nothing.

// File: rtl/pmu_enclr_pkg.sv
`timescale 1ns/1ps
package pmu_enclr_pkg;

  localparam int unsigned REG_W   = 64;
  localparam int unsigned EN_W    = 32;
  localparam int unsigned CYC_POS = 31;
  localparam int unsigned MAX_EVT = 31;
  localparam int unsigned LIM_W   = 5;

  typedef enum logic [1:0] {
    PRIV_APP    = 2'd0,
    PRIV_KERNEL = 2'd1,
    PRIV_HYP    = 2'd2,
    PRIV_MON    = 2'd3
  } priv_e;

  typedef logic [EN_W-1:0]  en_vec_t;
  typedef logic [REG_W-1:0] reg_word_t;

  // Partition limit applies only to guest levels with the hypervisor live.
  function automatic logic use_partition(input priv_e p, input logic hi, input logic ho);
    return hi & ho & ((p == PRIV_APP) || (p == PRIV_KERNEL));
  endfunction

  // Saturate a requested limit at the number of built counters.
  function automatic logic [LIM_W-1:0] clamp_limit(input logic [LIM_W-1:0] n,
                                                   input int unsigned top);
    int unsigned nn;
    nn = int'(n);
    if (nn > top) return LIM_W'(top);
    return n;
  endfunction

  // Accessible bits for a limit: events below n plus the cycle bit.
  function automatic en_vec_t limit_mask(input logic [LIM_W-1:0] n);
    en_vec_t m;
    m = '0;
    for (int i = 0; i < int'(MAX_EVT); i++) begin
      m[i] = (i < int'(n));
    end
    m[CYC_POS] = 1'b1;
    return m;
  endfunction

  // Bits that have storage behind them.
  function automatic en_vec_t built_mask(input int unsigned num_evt);
    en_vec_t m;
    m = '0;
    for (int i = 0; i < int'(MAX_EVT); i++) begin
      m[i] = (i < int'(num_evt));
    end
    m[CYC_POS] = 1'b1;
    return m;
  endfunction

  // Clear vector from a write: upper word dropped, limit applied.
  function automatic en_vec_t clear_vector(input logic we, input reg_word_t d,
                                           input en_vec_t acc);
    if (!we) return '0;
    return d[EN_W-1:0] & acc;
  endfunction

  // Read image: reserved word zero, hidden events zero.
  function automatic reg_word_t read_image(input en_vec_t en, input en_vec_t acc);
    return {{(REG_W-EN_W){1'b0}}, en & acc};
  endfunction

endpackage

// File: rtl/pmu_limit_sel.sv
`timescale 1ns/1ps
module pmu_limit_sel
  import pmu_enclr_pkg::*;
#(
  parameter int unsigned NUM_EVT = 31
) (
  input  priv_e            priv,
  input  logic             hyp_impl,
  input  logic             hyp_on,
  input  logic [LIM_W-1:0] part_n,
  input  logic [LIM_W-1:0] impl_n,
  output logic             use_part,
  output logic [LIM_W-1:0] n_eff,
  output en_vec_t          acc_mask
);

  localparam en_vec_t BUILT = built_mask(NUM_EVT);

  logic [LIM_W-1:0] n_raw;

  assign use_part = use_partition(priv, hyp_impl, hyp_on);
  assign n_raw    = use_part ? part_n : impl_n;
  assign n_eff    = clamp_limit(n_raw, NUM_EVT);
  assign acc_mask = limit_mask(n_eff) & BUILT;

endmodule

// File: rtl/pmu_enable_bank.sv
`timescale 1ns/1ps
module pmu_enable_bank
  import pmu_enclr_pkg::*;
#(
  parameter int unsigned NUM_EVT = 31
) (
  input  logic    clk,
  input  logic    rst_n,
  input  en_vec_t set_vec,
  input  en_vec_t clr_vec,
  output en_vec_t en_q
);

  for (genvar i = 0; i < int'(EN_W); i++) begin : g_bit
    if ((i < int'(NUM_EVT)) || (i == int'(CYC_POS))) begin : g_flop
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          q <= 1'b0;
        else if (clr_vec[i]) q <= 1'b0;
        else if (set_vec[i]) q <= 1'b1;
      end
      assign en_q[i] = q;
    end else begin : g_tie
      assign en_q[i] = 1'b0;
    end
  end

  en_vec_t set_live;
  assign set_live = set_vec & ~clr_vec;

  // R4
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec != '0) |=> ((en_q & $past(clr_vec)) == '0));

  // R3
  set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_live != '0) |=> ((en_q & $past(set_live)) == $past(set_live)));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_vec == '0) && (clr_vec == '0)) |=> $stable(en_q));

endmodule

// File: rtl/pmu_access_dec.sv
`timescale 1ns/1ps
module pmu_access_dec
  import pmu_enclr_pkg::*;
(
  input  logic      wr_en,
  input  reg_word_t wr_data,
  input  en_vec_t   acc_mask,
  input  en_vec_t   en_q,
  output en_vec_t   clr_vec,
  output reg_word_t rd_data
);

  assign clr_vec = clear_vector(wr_en, wr_data, acc_mask);
  assign rd_data = read_image(en_q, acc_mask);

endmodule

// File: rtl/pmu_enclr_reg.sv
`timescale 1ns/1ps
module pmu_enclr_reg
  import pmu_enclr_pkg::*;
#(
  parameter int unsigned NUM_EVT = 31
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [63:0] wr_data,
  input  logic        set_en,
  input  logic [31:0] set_data,
  input  logic [1:0]  priv_lvl,
  input  logic        hyp_impl,
  input  logic        hyp_on,
  input  logic [4:0]  part_n,
  input  logic [4:0]  impl_n,
  output logic [63:0] rd_data,
  output logic [31:0] cnt_en
);

  localparam en_vec_t BUILT = built_mask(NUM_EVT);

  logic             use_part;
  logic [LIM_W-1:0] n_eff;
  en_vec_t          acc_mask;
  en_vec_t          clr_vec;
  en_vec_t          set_vec;
  en_vec_t          en_q;

  pmu_limit_sel #(.NUM_EVT(NUM_EVT)) u_limit (
    .priv     (priv_e'(priv_lvl)),
    .hyp_impl (hyp_impl),
    .hyp_on   (hyp_on),
    .part_n   (part_n),
    .impl_n   (impl_n),
    .use_part (use_part),
    .n_eff    (n_eff),
    .acc_mask (acc_mask)
  );

  assign set_vec = set_en ? (set_data & BUILT) : '0;

  pmu_access_dec u_dec (
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .acc_mask (acc_mask),
    .en_q     (en_q),
    .clr_vec  (clr_vec),
    .rd_data  (rd_data)
  );

  pmu_enable_bank #(.NUM_EVT(NUM_EVT)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .en_q    (en_q)
  );

  assign cnt_en = en_q;

  // R5
  read_hides_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_data[EN_W-1:0] & ~cnt_en) == '0));

  // R7
  hidden_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(cnt_en) & ~cnt_en) & ~$past(acc_mask)) == '0));

  // R8
  limit_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(n_eff) <= int'(NUM_EVT)));

  // R6
  ctx_part_chk: assert property (@(posedge clk) disable iff (!rst_n)
    use_part |-> (n_eff <= part_n));

  // R6
  ctx_impl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !use_part |-> (n_eff <= impl_n));

endmodule

// File: tb/pmu_enclr_reg_tb.sv
`timescale 1ns/1ps
module pmu_enclr_reg_tb;

  localparam int NE = 6;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, set_en, hyp_impl, hyp_on;
  logic [63:0] wr_data;
  logic [31:0] set_data;
  logic [1:0]  priv_lvl;
  logic [4:0]  part_n, impl_n;
  logic [63:0] rd_data;
  logic [31:0] cnt_en;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  logic [31:0] model = '0;

  always #4 clk = ~clk;

  pmu_enclr_reg #(.NUM_EVT(NE)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .set_en(set_en), .set_data(set_data), .priv_lvl(priv_lvl),
    .hyp_impl(hyp_impl), .hyp_on(hyp_on), .part_n(part_n),
    .impl_n(impl_n), .rd_data(rd_data), .cnt_en(cnt_en)
  );

  function automatic logic [31:0] bmask(input int n);
    logic [31:0] m;
    int k;
    k = (n > NE) ? NE : n;
    m = 32'h8000_0000;
    for (int i = 0; i < k; i++) m[i] = 1'b1;
    return m;
  endfunction

  function automatic int sel_n();
    if (hyp_impl && hyp_on && (priv_lvl < 2'd2)) return int'(part_n);
    return int'(impl_n);
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic op(input logic w, input logic [63:0] wd, input logic s, input logic [31:0] sd);
    logic [31:0] m, clr, st;
    wr_en = w; wr_data = wd; set_en = s; set_data = sd;
    m   = bmask(sel_n());
    clr = w ? (wd[31:0] & m) : 32'h0;
    st  = s ? (sd & bmask(NE)) : 32'h0;
    @(posedge clk);
    model = (model | st) & ~clr;
    @(negedge clk);
    wr_en = 1'b0; set_en = 1'b0; wr_data = '0; set_data = '0;
    #1;
  endtask

  task automatic ctx(input logic [1:0] p, input logic hi, input logic ho,
                     input logic [4:0] pn, input logic [4:0] in);
    priv_lvl = p; hyp_impl = hi; hyp_on = ho; part_n = pn; impl_n = in;
    #1;
  endtask

  task automatic look(input string tag);
    chk({tag, " cnt_en"}, {32'h0, cnt_en}, {32'h0, model});
    chk({tag, " rd_data"}, rd_data, {32'h0, model & bmask(sel_n())});
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R1 watchdog act=hang exp=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; set_en = 1'b0; wr_data = '0; set_data = '0;
    priv_lvl = 2'd0; hyp_impl = 1'b0; hyp_on = 1'b0; part_n = 5'd0; impl_n = 5'd6;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 in reset", rd_data, 64'h0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1 after reset rd", rd_data, 64'h0);
    chk("R1 after reset cnt_en", {32'h0, cnt_en}, 64'h0);

    // R3 / R9 / R8: set everything, only built bits land
    op(1'b0, '0, 1'b1, 32'hFFFF_FFFF);
    chk("R3 set all cnt_en", {32'h0, cnt_en}, 64'h0000_0000_8000_003F);
    chk("R5 read all", rd_data, 64'h0000_0000_8000_003F);

    // R2: write of zero and of upper word only change nothing
    op(1'b1, 64'h0, 1'b0, '0);
    look("R2 zero write");
    op(1'b1, 64'hFFFF_FFFF_0000_0000, 1'b0, '0);
    look("R2 upper word write");

    // R2 R5 R7 R8: sweep limit via impl_n, hyp off
    for (int n = 0; n < 8; n++) begin
      ctx(2'd0, 1'b0, 1'b0, 5'd0, 5'(n));
      op(1'b0, '0, 1'b1, 32'hFFFF_FFFF);
      look($sformatf("R5 sweep n=%0d set", n));
      for (int j = 0; j < 8; j++) begin
        int b;
        b = (j < 6) ? j : ((j == 6) ? 31 : 40);
        op(1'b1, 64'h1 << b, 1'b0, '0);
        look($sformatf("R7 sweep n=%0d clr bit %0d", n, b));
      end
    end

    // R6: limit selection across all contexts
    for (int p = 0; p < 4; p++) begin
      for (int h = 0; h < 4; h++) begin
        ctx(2'(p), h[1], h[0], 5'd2, 5'd5);
        op(1'b0, '0, 1'b1, 32'hFFFF_FFFF);
        chk($sformatf("R6 ctx p=%0d h=%0d", p, h), rd_data,
            {32'h0, ((h == 3) && (p < 2)) ? 32'h8000_0003 : 32'h8000_001F});
      end
    end

    // R7: hidden enables survive and reappear
    ctx(2'd1, 1'b1, 1'b1, 5'd2, 5'd6);
    op(1'b0, '0, 1'b1, 32'hFFFF_FFFF);
    op(1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, '0);
    chk("R7 hidden kept cnt_en", {32'h0, cnt_en}, 64'h0000_0000_0000_003C);
    chk("R7 hidden read zero", rd_data, 64'h0);
    ctx(2'd2, 1'b1, 1'b1, 5'd2, 5'd6);
    chk("R7 reappear", rd_data, 64'h0000_0000_0000_003C);

    // R4: clear wins over a set on the same bit
    ctx(2'd3, 1'b0, 1'b0, 5'd0, 5'd6);
    op(1'b1, 64'hFFFF_FFFF, 1'b0, '0);
    chk("R2 all cleared", {32'h0, cnt_en}, 64'h0);
    wr_en = 1'b1; wr_data = 64'h8; set_en = 1'b1; set_data = 32'h8000_0018;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; set_en = 1'b0; wr_data = '0; set_data = '0;
    #1;
    chk("R4 clear wins", {32'h0, cnt_en}, 64'h0000_0000_8000_0010);
    model = 32'h8000_0010;

    // R8: oversize limit clamps
    ctx(2'd0, 1'b0, 1'b0, 5'd0, 5'd31);
    op(1'b0, '0, 1'b1, 32'h7FFF_FFC0);
    chk("R8 unbuilt never set", {32'h0, cnt_en}, 64'h0000_0000_8000_0010);
    op(1'b0, '0, 1'b1, 32'hFFFF_FFFF);
    chk("R8 clamp read", rd_data, 64'h0000_0000_8000_003F);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule